// File: doc/BRIEF.md
# Scaled System Timestamp Counter

This block keeps a never-resetting-by-software system timestamp for the rest of the chip. Inside it sits an 88-bit accumulator in 64.24 fixed point. On every clock in which counting is enabled, it adds an increment to the accumulator. That increment is either exactly one whole count or a programmable 32-bit value whose low 24 bits are a fraction. The upper 64 bits of the accumulator form the visible count. This count drives a direct output, so downstream timers can compare against it without going through the bus.

Software reaches the block through two 32-bit register frames that share one APB-style bus. Each frame has its own select line. The control frame holds:
- the control word, with run and scaling switches;
- the scale value;
- the writable count, one 32-bit half at a time;
- identification words.

The status frame gives read-only access to the count and its own identification bytes. Only word-aligned addresses decode. Every other address reads zero, and the bus never reports an error.

Top module: `tsc_scaled_counter`

## Requirements
- R1: The count is the top 64 bits of an 88-bit accumulator. While running with scaling on (control bit 2 = 1), each clock adds the zero-extended 32-bit scale value to the accumulator. A scale of 0x01000000 therefore advances the count by one per clock, and smaller values build up fractions that carry into the count. The accumulator wraps modulo 2^88.
- R2: While running with scaling off, the count advances by exactly one per clock, whatever the scale register holds.
- R3: While the run bit (control bit 0) is clear, the whole accumulator, fraction included, holds its value. Counting resumes from that value in the first clock after the run bit is set again.
- R4: The control word at control-frame offset 0x000 stores the following bits, and bits 31:5 always read zero whatever is written:
  - bit 0: run
  - bit 1: debug halt
  - bit 2: scale enable
  - bit 3: interrupt mask
  - bit 4: bus-error disable
- R5: In the control frame, the scale register is at 0x010, with an alias at 0x0D0. Offsets 0x004 and 0x0D4 always read zero, and writes to them change nothing.
- R6: A write to count low (control frame 0x008) or count high (0x00C) replaces only that 32-bit half. The other half keeps its current value and the 24 fraction bits are cleared. In that clock the write takes the place of the increment.
- R7: The control-frame identification word at 0x01C reads 0x00020001: bits 3:0 = 1, bits 18:17 = 1, all other bits zero. Writes to it are ignored.
- R8: The status frame returns the count low half at 0x000 and the high half at 0x004. Writes to any status-frame offset change nothing.
- R9: In both frames, the words at 0xFD0 through 0xFFC return a constant byte in bits 7:0, with zero above.
  - In ascending address order the bytes are 04, 00, 00, 00, xx, B0, 0B, 00, 0D, F0, 05, B1.
  - xx (at 0xFE0) is BA in the control frame and BB in the status frame.
- R10: After reset the control word is 0, the scale register is 0x01000000 and the count and fraction are 0.
- R11: Unmapped or non-word-aligned addresses read zero, and writes to them change nothing. With no frame selected, the read data is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Counter and bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_psel | input | 1 | Selects the control frame |
| sts_psel | input | 1 | Selects the status frame |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 12 | Byte address within the selected frame |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data of the selected frame |
| count_o | output | 64 | Visible timestamp count |

## Verification
Directed sequences target the following corner cases:
- A half-step scale must take two clocks per count and keep its leftover fraction across a pause. A design that dropped the fraction on hold, or ignored it, would read 2 or 4 instead of 3.
- A carry must cross from the low word into the high word. Missing carry logic would leave the high half at zero.
- The accumulator must wrap from all ones to a small value.
- A low-half write while running must keep the high half and replace the increment. A design that merged incorrectly, or also added a tick, would show a wrong high word or an off-by-one low word.
- The scaling bit must be ignored while scaling is off.

Random traffic then mixes writes to control, scale (at both aliases), count halves, read-only offsets, the status frame and unaligned addresses with reads over the whole map. A scoreboard built from the requirements compares the count output every cycle and every read value.

// File: rtl/tsc_pkg.sv
package tsc_pkg;

  localparam int unsigned ADDR_W = 12;

  // Control word, bit 0 at the bottom
  typedef struct packed {
    logic bus_err_off;
    logic irq_mask;
    logic scale_on;
    logic dbg_halt;
    logic run;
  } ctl_t;

  localparam int unsigned CTL_W = $bits(ctl_t);

  // Control frame byte offsets
  localparam logic [ADDR_W-1:0] OFF_CTL    = 12'h000;
  localparam logic [ADDR_W-1:0] OFF_STAT   = 12'h004;
  localparam logic [ADDR_W-1:0] OFF_COUNT  = 12'h008;
  localparam logic [ADDR_W-1:0] OFF_SCALE  = 12'h010;
  localparam logic [ADDR_W-1:0] OFF_IDENT  = 12'h01C;
  localparam logic [ADDR_W-1:0] OFF_SCALEA = 12'h0D0;
  localparam logic [ADDR_W-1:0] OFF_SCALE2 = 12'h0D4;
  // Status frame byte offsets
  localparam logic [ADDR_W-1:0] OFF_SCOUNT = 12'h000;

  localparam logic [31:0] IDENT_WORD = 32'h0002_0001;

  // Constant identification byte; zero outside the ID window
  function automatic logic [7:0] id_byte(input logic [ADDR_W-1:0] a,
                                         input logic is_status);
    logic [7:0] b;
    case (a)
      12'hFD0: b = 8'h04;
      12'hFE0: b = is_status ? 8'hBB : 8'hBA;
      12'hFE4: b = 8'hB0;
      12'hFE8: b = 8'h0B;
      12'hFF0: b = 8'h0D;
      12'hFF4: b = 8'hF0;
      12'hFF8: b = 8'h05;
      12'hFFC: b = 8'hB1;
      default: b = 8'h00;
    endcase
    return b;
  endfunction

endpackage

// File: rtl/tsc_accum.sv
module tsc_accum
  import tsc_pkg::*;
#(
  parameter int unsigned CNT_W   = 64,
  parameter int unsigned FRAC_W  = 24,
  parameter int unsigned SCALE_W = 32,
  parameter int unsigned DATA_W  = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     run,
  input  logic                     scale_on,
  input  logic [SCALE_W-1:0]       scale,
  input  logic [CNT_W/DATA_W-1:0]  ld_en,
  input  logic [DATA_W-1:0]        ld_data,
  output logic [CNT_W-1:0]         count
);

  localparam int unsigned ACC_W = CNT_W + FRAC_W;
  localparam int unsigned NH    = CNT_W / DATA_W;
  localparam logic [ACC_W-1:0] UNIT = ACC_W'(1) << FRAC_W;

  logic [ACC_W-1:0] acc_q, acc_d, step;
  logic [CNT_W-1:0] ld_cnt;
  logic             acc_ce;

  assign count = acc_q[ACC_W-1:FRAC_W];

  // Half-word merge for count writes
  for (genvar i = 0; i < NH; i++) begin : g_half
    assign ld_cnt[i*DATA_W +: DATA_W] = ld_en[i] ? ld_data
                                                 : count[i*DATA_W +: DATA_W];
  end

  assign step   = scale_on ? ACC_W'(scale) : UNIT;
  assign acc_ce = (|ld_en) | run;

  always_comb begin
    acc_d = acc_q;
    if (|ld_en)   acc_d = {ld_cnt, {FRAC_W{1'b0}}};
    else if (run) acc_d = acc_q + step;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc_q <= '0;
    else if (acc_ce) acc_q <= acc_d;
  end

  AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && ld_en == '0) |=> $stable(acc_q)); // R3

  AST_UNIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !scale_on && ld_en == '0) |=> count == $past(count) + CNT_W'(1)); // R2

  AST_FRAC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_en != '0) |=> acc_q[FRAC_W-1:0] == '0); // R6

  for (genvar k = 0; k < NH; k++) begin : g_keep
    AST_HALF_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_en != '0 && !ld_en[k]) |=>
        count[k*DATA_W +: DATA_W] == $past(count[k*DATA_W +: DATA_W])); // R6
  end

endmodule

// File: rtl/tsc_ctrl_frame.sv
module tsc_ctrl_frame
  import tsc_pkg::*;
#(
  parameter int unsigned CNT_W     = 64,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned SCALE_W   = 32,
  parameter logic [31:0] SCALE_RST = 32'h0100_0000
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     sel,
  input  logic                     penable,
  input  logic                     pwrite,
  input  logic [ADDR_W-1:0]        paddr,
  input  logic [DATA_W-1:0]        pwdata,
  input  logic [CNT_W-1:0]         count,
  output logic [DATA_W-1:0]        rdata,
  output logic                     run,
  output logic                     scale_on,
  output logic [SCALE_W-1:0]       scale,
  output logic [CNT_W/DATA_W-1:0]  ld_en
);

  localparam int unsigned NH = CNT_W / DATA_W;

  ctl_t               ctl_q, ctl_d;
  logic [SCALE_W-1:0] scale_q, scale_d;
  logic               wr, hit_ctl, hit_scale;

  assign wr        = sel & penable & pwrite;
  assign hit_ctl   = wr && (paddr == OFF_CTL);
  assign hit_scale = wr && (paddr == OFF_SCALE || paddr == OFF_SCALEA);

  for (genvar i = 0; i < NH; i++) begin : g_ld
    assign ld_en[i] = wr && (paddr == ADDR_W'(OFF_COUNT + 4 * i));
  end

  always_comb begin
    ctl_d   = ctl_q;
    scale_d = scale_q;
    if (hit_ctl)   ctl_d   = ctl_t'(pwdata[CTL_W-1:0]);
    if (hit_scale) scale_d = pwdata[SCALE_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q   <= '0;
      scale_q <= SCALE_W'(SCALE_RST);
    end else begin
      if (hit_ctl)   ctl_q   <= ctl_d;
      if (hit_scale) scale_q <= scale_d;
    end
  end

  assign run      = ctl_q.run;
  assign scale_on = ctl_q.scale_on;
  assign scale    = scale_q;

  always_comb begin
    rdata = '0;
    if (paddr == OFF_CTL)                                rdata = DATA_W'(ctl_q);
    else if (paddr == OFF_SCALE || paddr == OFF_SCALEA)  rdata = DATA_W'(scale_q);
    else if (paddr == OFF_IDENT)                         rdata = DATA_W'(IDENT_WORD);
    else                                                 rdata = DATA_W'(id_byte(paddr, 1'b0));
    for (int i = 0; i < NH; i++) begin
      if (paddr == ADDR_W'(OFF_COUNT + 4 * i)) rdata = count[i*DATA_W +: DATA_W];
    end
  end

  AST_CTL_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (paddr == OFF_CTL) |-> rdata[DATA_W-1:CTL_W] == '0); // R4

  AST_SCALE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_scale |=> $stable(scale_q)); // R5

  AST_STAT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (paddr == OFF_STAT || paddr == OFF_SCALE2) |-> rdata == '0); // R5

endmodule

// File: rtl/tsc_stat_frame.sv
module tsc_stat_frame
  import tsc_pkg::*;
#(
  parameter int unsigned CNT_W  = 64,
  parameter int unsigned DATA_W = 32
) (
  input  logic [ADDR_W-1:0] paddr,
  input  logic [CNT_W-1:0]  count,
  output logic [DATA_W-1:0] rdata
);

  localparam int unsigned NH = CNT_W / DATA_W;

  always_comb begin
    rdata = DATA_W'(id_byte(paddr, 1'b1));
    for (int i = 0; i < NH; i++) begin
      if (paddr == ADDR_W'(OFF_SCOUNT + 4 * i)) rdata = count[i*DATA_W +: DATA_W];
    end
  end

endmodule

// File: rtl/tsc_scaled_counter.sv
module tsc_scaled_counter
  import tsc_pkg::*;
#(
  parameter int unsigned CNT_W   = 64,
  parameter int unsigned FRAC_W  = 24,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned SCALE_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_psel,
  input  logic              sts_psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [11:0]       paddr,
  input  logic [31:0]       pwdata,
  output logic [31:0]       prdata,
  output logic [63:0]       count_o
);

  localparam int unsigned NH = CNT_W / DATA_W;

  logic               run, scale_on;
  logic [SCALE_W-1:0] scale;
  logic [NH-1:0]      ld_en;
  logic [CNT_W-1:0]   count;
  logic [DATA_W-1:0]  ctl_rd, sts_rd;

  tsc_ctrl_frame #(
    .CNT_W(CNT_W), .DATA_W(DATA_W), .SCALE_W(SCALE_W)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel      (ctl_psel),
    .penable  (penable),
    .pwrite   (pwrite),
    .paddr    (paddr),
    .pwdata   (pwdata),
    .count    (count),
    .rdata    (ctl_rd),
    .run      (run),
    .scale_on (scale_on),
    .scale    (scale),
    .ld_en    (ld_en)
  );

  tsc_accum #(
    .CNT_W(CNT_W), .FRAC_W(FRAC_W), .SCALE_W(SCALE_W), .DATA_W(DATA_W)
  ) u_acc (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .scale_on (scale_on),
    .scale    (scale),
    .ld_en    (ld_en),
    .ld_data  (pwdata),
    .count    (count)
  );

  tsc_stat_frame #(
    .CNT_W(CNT_W), .DATA_W(DATA_W)
  ) u_stat (
    .paddr (paddr),
    .count (count),
    .rdata (sts_rd)
  );

  assign prdata  = ctl_psel ? ctl_rd : (sts_psel ? sts_rd : '0);
  assign count_o = count;

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_psel && !sts_psel) |-> prdata == '0); // R11

  AST_STS_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_psel && !ctl_psel && !run) |=> $stable(count_o)); // R8

endmodule

// File: tb/tsc_scaled_counter_bench.sv
module tsc_scaled_counter_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ctl_psel, sts_psel, penable, pwrite;
  logic [11:0] paddr;
  logic [31:0] pwdata;
  logic [31:0] prdata;
  logic [63:0] count_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  tsc_scaled_counter u_tsc_scaled_counter (
    .clk(clk), .rst_n(rst_n), .ctl_psel(ctl_psel), .sts_psel(sts_psel),
    .penable(penable), .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata),
    .prdata(prdata), .count_o(count_o)
  );

  // Reference model from the requirements
  logic [4:0]  m_ctl;
  logic [31:0] m_scale;
  logic [87:0] m_acc;
  bit          m_wr;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctl = 5'h0; m_scale = 32'h0100_0000; m_acc = 88'h0;
    end else begin
      m_wr = ctl_psel && penable && pwrite;
      if (m_wr && paddr == 12'h008)      m_acc = {m_acc[87:56], pwdata, 24'h0};
      else if (m_wr && paddr == 12'h00C) m_acc = {pwdata, m_acc[55:24], 24'h0};
      else if (m_ctl[0])
        m_acc = m_acc + (m_ctl[2] ? {56'h0, m_scale} : (88'h1 << 24));
      if (m_wr && paddr == 12'h000) m_ctl = pwdata[4:0];
      if (m_wr && (paddr == 12'h010 || paddr == 12'h0D0)) m_scale = pwdata;
    end
  end

  function automatic logic [31:0] exp_id(input logic [11:0] a, input bit st);
    case (a)
      12'hFD0: return 32'h04;
      12'hFE0: return st ? 32'hBB : 32'hBA;
      12'hFE4: return 32'hB0;
      12'hFE8: return 32'h0B;
      12'hFF0: return 32'h0D;
      12'hFF4: return 32'hF0;
      12'hFF8: return 32'h05;
      12'hFFC: return 32'hB1;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] exp_read(input bit st, input logic [11:0] a);
    logic [63:0] c;
    c = m_acc[87:24];
    if (st) begin
      if (a == 12'h000) return c[31:0];
      if (a == 12'h004) return c[63:32];
      return exp_id(a, 1'b1);
    end
    case (a)
      12'h000: return {27'h0, m_ctl};
      12'h008: return c[31:0];
      12'h00C: return c[63:32];
      12'h010, 12'h0D0: return m_scale;
      12'h01C: return 32'h0002_0001;
      default: return exp_id(a, 1'b0);
    endcase
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Count output against model every cycle (R1 R2 R3 R6)
  always @(negedge clk) begin
    if (rst_n === 1'b1 && !done) check("R1 count_o", count_o, m_acc[87:24]);
  end

  task automatic bus_wr(input bit st, input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    ctl_psel = !st; sts_psel = st; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
    @(negedge clk);
    penable = 1'b1;
    @(negedge clk);
    ctl_psel = 1'b0; sts_psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic bus_rd(input bit st, input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    ctl_psel = !st; sts_psel = st; pwrite = 1'b0; paddr = a; penable = 1'b0;
    @(negedge clk);
    penable = 1'b1;
    #1 d = prdata;
    @(negedge clk);
    ctl_psel = 1'b0; sts_psel = 1'b0; penable = 1'b0;
  endtask

  task automatic rd_chk(input string req, input bit st, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] d;
    bus_rd(st, a, d);
    check(req, d, exp);
  endtask

  task automatic rd_model(input string req, input bit st, input logic [11:0] a);
    logic [31:0] d, e;
    @(negedge clk);
    ctl_psel = !st; sts_psel = st; pwrite = 1'b0; paddr = a; penable = 1'b0;
    @(negedge clk);
    penable = 1'b1;
    #1 d = prdata; e = exp_read(st, a);
    check(req, d, e);
    @(negedge clk);
    ctl_psel = 1'b0; sts_psel = 1'b0; penable = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  logic [11:0] addrs [20];

  initial begin
    void'($urandom(32'h5EED_0C01));
    addrs = '{12'h000, 12'h004, 12'h008, 12'h00C, 12'h010, 12'h01C, 12'h0D0, 12'h0D4,
              12'hFD0, 12'hFD4, 12'hFE0, 12'hFE4, 12'hFE8, 12'hFEC, 12'hFF0, 12'hFF8,
              12'hFFC, 12'h009, 12'h100, 12'h014};
    rst_n = 1'b0; ctl_psel = 0; sts_psel = 0; penable = 0; pwrite = 0; paddr = 0; pwdata = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R10 reset state
    check("R10 prdata idle", prdata, 32'h0);
    rd_chk("R10 control", 0, 12'h000, 32'h0);
    rd_chk("R10 scale", 0, 12'h010, 32'h0100_0000);
    rd_chk("R10 count lo", 0, 12'h008, 32'h0);
    rd_chk("R10 count hi", 1, 12'h004, 32'h0);
    // R7 / R9 / R5 constants
    rd_chk("R7 ident", 0, 12'h01C, 32'h0002_0001);
    rd_chk("R9 ctl id FE0", 0, 12'hFE0, 32'hBA);
    rd_chk("R9 sts id FE0", 1, 12'hFE0, 32'hBB);
    rd_chk("R9 id FFC", 1, 12'hFFC, 32'hB1);
    rd_chk("R5 offset 0x004", 0, 12'h004, 32'h0);
    bus_wr(0, 12'h0D4, 32'hFFFF_FFFF);
    rd_chk("R5 offset 0x0D4", 0, 12'h0D4, 32'h0);
    bus_wr(0, 12'h0D0, 32'h0080_0000);
    rd_chk("R5 scale alias", 0, 12'h010, 32'h0080_0000);
    // R4 reserved bits
    bus_wr(0, 12'h000, 32'hFFFF_FFE0);
    rd_chk("R4 reserved zero", 0, 12'h000, 32'h0);
    bus_wr(0, 12'h01C, 32'h0);
    rd_chk("R7 ident write ignored", 0, 12'h01C, 32'h0002_0001);

    // R1 / R3 half-step scale, fraction kept across hold: 3 ticks each run
    bus_wr(0, 12'h000, 32'h5);
    bus_wr(0, 12'h000, 32'h0);
    rd_chk("R1 half step 1.5", 0, 12'h008, 32'h1);
    bus_wr(0, 12'h000, 32'h5);
    bus_wr(0, 12'h000, 32'h0);
    rd_chk("R3 fraction kept", 0, 12'h008, 32'h3);

    // R2 carry into high word, scaling off ignores scale register
    bus_wr(0, 12'h008, 32'hFFFF_FFFF);
    bus_wr(0, 12'h00C, 32'h0);
    bus_wr(0, 12'h000, 32'h1);
    bus_wr(0, 12'h000, 32'h0);
    rd_chk("R2 carry lo", 0, 12'h008, 32'h2);
    rd_chk("R2 carry hi", 0, 12'h00C, 32'h1);

    // R1 wrap from all ones
    bus_wr(0, 12'h008, 32'hFFFF_FFFF);
    bus_wr(0, 12'h00C, 32'hFFFF_FFFF);
    bus_wr(0, 12'h0D0, 32'h0100_0000);
    bus_wr(0, 12'h000, 32'h5);
    bus_wr(0, 12'h000, 32'h0);
    rd_chk("R1 wrap lo", 1, 12'h000, 32'h2);
    rd_chk("R1 wrap hi", 1, 12'h004, 32'h0);

    // R6 low write while running keeps high, replaces the tick
    bus_wr(0, 12'h00C, 32'h5);
    bus_wr(0, 12'h008, 32'h0);
    bus_wr(0, 12'h000, 32'h1);
    bus_wr(0, 12'h008, 32'h100);
    bus_wr(0, 12'h000, 32'h0);
    rd_chk("R6 lo written", 0, 12'h008, 32'h103);
    rd_chk("R6 hi kept", 0, 12'h00C, 32'h5);

    // R8 status writes ignored
    bus_wr(1, 12'h000, 32'hDEAD_BEEF);
    bus_wr(1, 12'h004, 32'hDEAD_BEEF);
    rd_chk("R8 status write ignored", 1, 12'h000, 32'h103);
    // R11 unaligned write ignored
    bus_wr(0, 12'h009, 32'h7);
    rd_chk("R11 unaligned", 0, 12'h008, 32'h103);

    // Random traffic against the model
    for (int n = 0; n < 3000; n++) begin
      int op;
      logic [31:0] d;
      op = $urandom_range(0, 9);
      d = $urandom;
      case (op)
        0, 1: bus_wr(0, 12'h000, d);
        2: bus_wr(0, ($urandom_range(0, 1) != 0) ? 12'h010 : 12'h0D0,
                  ($urandom_range(0, 1) != 0) ? d : 32'h0100_0000);
        3: bus_wr(0, ($urandom_range(0, 1) != 0) ? 12'h008 : 12'h00C, d);
        4: bus_wr($urandom_range(0, 1) != 0, addrs[$urandom_range(0, 19)], d);
        5: repeat ($urandom_range(1, 8)) @(negedge clk);
        default: rd_model("R11 R8 R9 random read", $urandom_range(0, 1) != 0,
                          addrs[$urandom_range(0, 19)]);
      endcase
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule